// File: doc/BRIEF.md
# Host-to-Local Address Remap Window

This block translates firmware-cycle addresses from a host-side port into addresses on a local system bus through one programmable window. A 32-bit request address is compared with a programmed host window at 64 KiB granularity. When the request falls inside the window, the block claims it. The upper 16 bits of the address are rebuilt from a programmed local base under a two-part mask, and the lower 16 bits are carried through as they arrived. The block registers both the claim flag and the translated address, and presents them one cycle after the request strobe.

Software programs the window through a simple 32-bit register port. The port reaches a control register, a mode/status register, a base register and a mask register. Each register splits into two 16-bit halves:

- **Base register:** the upper half is the local target base and the lower half is the host window base.
- **Mask register:** the upper half marks address bits to replace from the local base, and the lower half marks bits to keep from the request.

Translation needs two separate enable bits in the control register. The mode/status register holds one plain read/write forwarding-mode bit. Its other bits are status flags that hardware strobes set and software clears by writing 1.

Top module: `fw_remap_window`

## Requirements
- R1: After reset, all four registers read as zero and no request is claimed.
- R2: A request is claimed only when control bit 8 (host-to-local enable) and control bit 10 (firmware-cycle enable) are both 1. With either bit at 0, loc_req stays 0.
- R3: A request hits when (req_addr[31:16] & ~keep) equals (host_base & ~keep). Here keep is mask bits [15:0] and host_base is base bits [15:0]. On a miss, loc_req stays 0.
- R4: On a hit, loc_addr[31:16] equals (local_base & replace) | (req_addr[31:16] & keep). Here local_base is base bits [31:16] and replace is mask bits [31:16]. A bit set in neither mask half comes out as 0.
- R5: On a hit, loc_addr[15:0] equals req_addr[15:0].
- R6: loc_req is a one-cycle pulse in the cycle after a req_valid strobe. It is never raised without a strobe in the previous cycle.
- R7: In the mode/status register (offset 0x84), writing 1 to a status bit (any bit other than 17) clears it. Writing 0 to a status bit leaves it unchanged.
- R8: Each stat_set bit sets the matching status bit. When a set and a write-1 clear of the same bit arrive in the same cycle, the bit ends up set.
- R9: Bit 17 of the mode/status register is plain read/write. It drives fwd_mode, and stat_set[17] has no effect on it.
- R10: The registers sit at byte offsets control 0x80, mode/status 0x84, base 0x88 and mask 0x8C. Control, base and mask read back exactly as written. reg_rdata updates one cycle after reg_rd. Any other offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| stat_set | input | 32 | Per-bit status set strobes |
| req_valid | input | 1 | Host request strobe |
| req_addr | input | 32 | Host request address |
| loc_req | output | 1 | Claimed request, one cycle after strobe |
| loc_addr | output | 32 | Translated local address |
| fwd_mode | output | 1 | Forwarding mode bit |

## Verification
The assertions assume the following about the inputs:

- Between cycles the request address is stable only as a sampled value. Each property compares loc_addr against the request captured one edge earlier.
- stat_set is 0 during reset.

The bench changes every input on the falling clock edge. It holds req_valid and stat_set low through reset, and it raises req_valid for one cycle per request. Each request's result is checked before the next request is issued, so a pulse is never mistaken for a held level.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_CTRL = 8'h80;
  localparam logic [REG_AW-1:0] OFS_STAT = 8'h84;
  localparam logic [REG_AW-1:0] OFS_BASE = 8'h88;
  localparam logic [REG_AW-1:0] OFS_MASK = 8'h8C;
  localparam int CTRL_H2L_BIT = 8;
  localparam int CTRL_FWC_BIT = 10;
  localparam int MODE_FWD_BIT = 17;
endpackage

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     stat_set,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     ctrl,
  output logic [DW-1:0]     stat,
  output logic [DW-1:0]     base,
  output logic [DW-1:0]     mask
);
  logic wr_ctrl, wr_stat, wr_base, wr_mask;

  assign wr_ctrl = wr && (addr == OFS_CTRL);
  assign wr_stat = wr && (addr == OFS_STAT);
  assign wr_base = wr && (addr == OFS_BASE);
  assign wr_mask = wr && (addr == OFS_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      base <= '0;
      mask <= '0;
    end else begin
      if (wr_ctrl) ctrl <= wdata;
      if (wr_base) base <= wdata;
      if (wr_mask) mask <= wdata;
    end
  end

  // One slice per status bit: the mode bit is plain storage, the rest are sticky flags
  for (genvar i = 0; i < DW; i++) begin : g_stat
    if (i == MODE_FWD_BIT) begin : g_mode
      always_ff @(posedge clk) begin
        if (rst)          stat[i] <= 1'b0;
        else if (wr_stat) stat[i] <= wdata[i];
      end
    end else begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                       stat[i] <= 1'b0;
        else if (stat_set[i])          stat[i] <= 1'b1;
        else if (wr_stat && wdata[i])  stat[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        OFS_CTRL: rdata <= ctrl;
        OFS_STAT: rdata <= stat;
        OFS_BASE: rdata <= base;
        OFS_MASK: rdata <= mask;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
  parameter int AW = 32,
  localparam int HW = AW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [HW-1:0] local_base,
  input  logic [HW-1:0] host_base,
  input  logic [HW-1:0] repl_mask,
  input  logic [HW-1:0] keep_mask,
  output logic          loc_req,
  output logic [AW-1:0] loc_addr
);
  logic [HW-1:0] req_hi, new_hi;
  logic          hit;

  assign req_hi = req_addr[AW-1:HW];
  assign hit    = ((req_hi ^ host_base) & ~keep_mask) == '0;
  assign new_hi = (local_base & repl_mask) | (req_hi & keep_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_req  <= 1'b0;
      loc_addr <= '0;
    end else begin
      loc_req <= req_valid && en && hit;
      if (req_valid && en && hit) loc_addr <= {new_hi, req_addr[HW-1:0]};
    end
  end
endmodule

// File: rtl/fw_remap_window.sv
module fw_remap_window
  import remap_pkg::*;
#(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DW-1:0]     stat_set,
  input  logic              req_valid,
  input  logic [DW-1:0]     req_addr,
  output logic              loc_req,
  output logic [DW-1:0]     loc_addr,
  output logic              fwd_mode
);
  logic [DW-1:0] ctrl_q, stat_q, base_q, mask_q;
  logic          win_en;

  remap_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .stat_set(stat_set), .rdata(reg_rdata),
    .ctrl(ctrl_q), .stat(stat_q), .base(base_q), .mask(mask_q)
  );

  assign win_en   = ctrl_q[CTRL_H2L_BIT] & ctrl_q[CTRL_FWC_BIT];
  assign fwd_mode = stat_q[MODE_FWD_BIT];

  remap_xlate #(.AW(DW)) u_xlate (
    .clk(clk), .rst(rst), .en(win_en), .req_valid(req_valid),
    .req_addr(req_addr),
    .local_base(base_q[DW-1:HW]), .host_base(base_q[HW-1:0]),
    .repl_mask(mask_q[DW-1:HW]), .keep_mask(mask_q[HW-1:0]),
    .loc_req(loc_req), .loc_addr(loc_addr)
  );
endmodule

// File: rtl/remap_chk.sv
module remap_chk
  import remap_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DW-1:0]     stat_set,
  input logic              req_valid,
  input logic [DW-1:0]     req_addr,
  input logic              loc_req,
  input logic [DW-1:0]     loc_addr,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     stat_q,
  input logic [DW-1:0]     mask_q
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] MODE_M = DW'(1) << MODE_FWD_BIT;

  a_r6_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> !loc_req);

  a_r2_both_enables: assert property (@(posedge clk) disable iff (rst)
    loc_req |-> ($past(ctrl_q[CTRL_H2L_BIT]) && $past(ctrl_q[CTRL_FWC_BIT])));

  a_r5_low_pass: assert property (@(posedge clk) disable iff (rst)
    loc_req |-> (loc_addr[HW-1:0] == $past(req_addr[HW-1:0])));

  a_r4_keep_bits: assert property (@(posedge clk) disable iff (rst)
    loc_req |-> (((loc_addr[DW-1:HW] ^ $past(req_addr[DW-1:HW])) & $past(mask_q[HW-1:0])) == '0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    ((stat_set & ~MODE_M) != '0) |=> ((($past(stat_set) & ~MODE_M) & ~stat_q) == '0));

  a_r9_mode_isolated: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == OFS_STAT) |=> $stable(stat_q[MODE_FWD_BIT]));
endmodule

bind fw_remap_window remap_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .stat_set(stat_set), .req_valid(req_valid), .req_addr(req_addr),
  .loc_req(loc_req), .loc_addr(loc_addr), .ctrl_q(ctrl_q),
  .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/sim_fw_remap_window.sv
module sim_fw_remap_window;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] stat_set = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        loc_req;
  logic [31:0] loc_addr;
  logic        fwd_mode;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_remap_window u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_set(stat_set),
    .req_valid(req_valid), .req_addr(req_addr), .loc_req(loc_req),
    .loc_addr(loc_addr), .fwd_mode(fwd_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic chk_req(input string tag, input logic [31:0] a, input logic hit,
                         input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " hit"}, {31'b0, loc_req}, {31'b0, hit});
    if (hit) check({tag, " addr"}, loc_addr, exp);
    @(negedge clk);
    check({tag, " pulse R6"}, {31'b0, loc_req}, 32'b0);
  endtask

  task automatic t_reset;
    chk_rd("R1 ctrl", 8'h80, 0);
    chk_rd("R1 stat", 8'h84, 0);
    chk_rd("R1 base", 8'h88, 0);
    chk_rd("R1 mask", 8'h8C, 0);
    chk_req("R1 idle", 32'h0000_1234, 1'b0, 0);
  endtask

  task automatic t_regs;
    wr_reg(8'h88, 32'h1234_0E00);
    wr_reg(8'h8C, 32'hFE00_01FF);
    chk_rd("R10 base", 8'h88, 32'h1234_0E00);
    chk_rd("R10 mask", 8'h8C, 32'hFE00_01FF);
    wr_reg(8'h90, 32'hFFFF_FFFF);
    chk_rd("R10 unmapped", 8'h90, 0);
  endtask

  task automatic t_enables;
    wr_reg(8'h80, 32'h0000_0100);
    chk_req("R2 only h2l", 32'h0E05_ABCD, 1'b0, 0);
    wr_reg(8'h80, 32'h0000_0400);
    chk_req("R2 only fwc", 32'h0E05_ABCD, 1'b0, 0);
    wr_reg(8'h80, 32'h0000_0500);
    chk_rd("R10 ctrl", 8'h80, 32'h0000_0500);
    chk_req("R2 both", 32'h0E05_ABCD, 1'b1, 32'h1205_ABCD);
  endtask

  task automatic t_xlate;
    chk_req("R3 R4 top of window", 32'h0FFF_0001, 1'b1, 32'h13FF_0001);
    chk_req("R5 low bits", 32'h0E00_FFFF, 1'b1, 32'h1200_FFFF);
    chk_req("R3 miss above", 32'h1005_0000, 1'b0, 0);
    chk_req("R3 miss below", 32'h0C00_0000, 1'b0, 0);
    wr_reg(8'h88, 32'h1234_0E10);
    chk_req("R3 host bits under keep ignored", 32'h0E05_0042, 1'b1, 32'h1205_0042);
    wr_reg(8'h8C, 32'hF000_00FF);
    chk_req("R4 neither half zero", 32'h0E05_0042, 1'b1, 32'h1005_0042);
  endtask

  task automatic t_status;
    @(negedge clk); stat_set = 32'h0002_0009;
    @(negedge clk); stat_set = 0;
    chk_rd("R8 set R9 ignored", 8'h84, 32'h0000_0009);
    check("R9 fwd_mode low", {31'b0, fwd_mode}, 0);
    wr_reg(8'h84, 32'h0000_0001);
    chk_rd("R7 w1c", 8'h84, 32'h0000_0008);
    wr_reg(8'h84, 32'h0000_0000);
    chk_rd("R7 write zero", 8'h84, 32'h0000_0008);
    @(negedge clk);
    stat_set = 32'h0000_0008; reg_wr = 1'b1; reg_addr = 8'h84; reg_wdata = 32'h0000_0008;
    @(negedge clk);
    stat_set = 0; reg_wr = 1'b0;
    chk_rd("R8 set wins", 8'h84, 32'h0000_0008);
    wr_reg(8'h84, 32'h0002_0000);
    chk_rd("R9 mode set", 8'h84, 32'h0002_0008);
    check("R9 fwd_mode high", {31'b0, fwd_mode}, 1);
    wr_reg(8'h84, 32'h0000_0008);
    chk_rd("R9 mode clear", 8'h84, 32'h0000_0000);
    check("R9 fwd_mode cleared", {31'b0, fwd_mode}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_regs;
    t_enables;
    t_xlate;
    t_status;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule